// File: doc/BRIEF.md
# 16-bit Execute Unit with Condition Flags

This block is the execute stage of a small 16-bit RISC core. Each cycle it takes one instruction word and two operand values, already read from the register files. It returns a result, a register write enable, a branch-taken decision and an illegal-instruction indication. It also keeps four condition flags (negative, zero, overflow, carry) in registers. The flags feed the add-with-carry path and conditional branches in later cycles.

The word is decoded by class (bits 15:14). The register class holds arithmetic, logic, multiply-half and shift functions in bits 7:3. The immediate class holds the 8-bit immediate operations, conditional branches and jumps, chosen by bits 10:8. Shift amounts are a two-bit step count. A mode bit (bit 3) scales that count by one or by four, so one shifter covers 0–3 and 0/4/8/12 bit distances. Load and store classes belong to the memory stage, so this unit passes them through with no effect.

Top module: `exec_unit`

## Requirements
- R1: After reset, all four flags are 0. While `inValid` is low, `wrEn`, `branchTaken` and `illegal` stay 0 and no flag changes.
- R2: Class 10 and 11 words (bits 15:14) give no register write, no branch and no illegal indication, and they leave the flags unchanged.
- R3: Register class functions 00000/00100 (add) and 00001/00101 (sub) write opA+opB or opA−opB. They set N (result bit 15), Z (result zero), O (signed overflow) and C (carry out for add, no-borrow for sub).
- R4: Functions 00010/00110 (or), 00011/00111 (and), 01001 (xor) and 01010 (not opA) write the logic result. They set N and Z, clear O and keep C.
- R5: Function 01000 writes opA+opB+C, where C is the stored carry flag, and updates all four flags as an add does. Two consecutive steps chain a carry.
- R6: Function 01011 writes the upper half and 01100 the lower half of the unsigned 32-bit product opA×opB. Flags are unchanged.
- R7: Bits 7:4 = 0111/1000/1001 shift opA left, right logical or right arithmetic by the step instr[1:0]. With bit 3 low the amount is the step; with bit 3 high it is step×4. Flags are unchanged.
- R8: Bits 7:4 = 1010/1011/1100 perform the same three shifts with the step taken from opB[1:0], scaled by bit 3 in the same way.
- R9: In class 01, bits 10:8 select the operation and imm = instr[7:0]. 000 writes opA+sext(imm) and 001 writes opA−sext(imm), both with all flags set as in R3. 011 writes opA & zext(imm) with flags as in R4. 100 writes {imm, 8'h00} with no flag change.
- R10: Class 01 op 010 (compare) sets flags as opA−sext(imm). Register function 11010 (test) sets N and Z from opA, clears O and keeps C. Neither writes a register.
- R11: Class 01 op 101 takes the branch when any flag selected by the mask is set: bit 13 selects N, bit 12 selects Z, bit 11 selects O. Ops 110 and 111 always take the branch. None of them writes a register or changes a flag.
- R12: Register class functions 11011, 01101 and 111xx raise `illegal`, with no write, no branch and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| opA | input | 16 | First source operand |
| opB | input | 16 | Second source operand |
| result | output | 16 | Value to write back |
| wrEn | output | 1 | Register write enable |
| branchTaken | output | 1 | Branch or jump taken |
| illegal | output | 1 | Undefined function code |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagO | output | 1 | Stored overflow flag |
| flagC | output | 1 | Stored carry flag |

## Verification
The hardest cases are the ones that depend on history through the stored flags. These are add-with-carry consuming a carry produced one instruction earlier, and branches whose outcome depends on which earlier instruction last touched each flag. The stimulus first issues chosen add, subtract and compare words with boundary operands such as 0xFFFF+1 and 0x7FFF+1. Each is followed directly by the dependent add-with-carry or branch. A bench model of the flags advances with every issued word, so random sequences also carry flag state from one operation into the next.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int IMM_W = 8;

  localparam logic [1:0] CLS_REG  = 2'b00;
  localparam logic [1:0] CLS_IMM  = 2'b01;

  typedef enum logic [3:0] {
    OP_PASS, OP_ADD, OP_SUB, OP_ADC, OP_AND, OP_OR, OP_XOR, OP_NOT,
    OP_MULH, OP_MULL, OP_SLL, OP_SRL, OP_SRA, OP_LUI
  } aluOpE;

  // Strobes from decode into the datapath
  typedef struct packed {
    aluOpE aluOp;
    logic  useImm;    // second operand comes from the immediate
    logic  immSext;   // immediate is sign-extended
    logic  shiftReg;  // shift step taken from opB
    logic  wrEn;
    logic  setNZ;
    logic  setArith;  // O and C come from the adder
    logic  clrO;
    logic  condBr;
    logic  jump;
    logic  illegal;
  } ctrlS;

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] cls,
  input  logic [2:0] immOp,
  input  logic [4:0] func,
  output ctrlS       strb
);

  always_comb begin
    strb = '0;
    strb.aluOp = OP_PASS;
    if (inValid) begin
      unique case (cls)
        CLS_REG: begin
          casez (func)
            5'b00?00: begin strb.aluOp = OP_ADD; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            5'b00?01: begin strb.aluOp = OP_SUB; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            5'b00?10: begin strb.aluOp = OP_OR;  strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            5'b00?11: begin strb.aluOp = OP_AND; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            5'b01000: begin strb.aluOp = OP_ADC; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            5'b01001: begin strb.aluOp = OP_XOR; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            5'b01010: begin strb.aluOp = OP_NOT; strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            5'b01011: begin strb.aluOp = OP_MULH; strb.wrEn = 1'b1; end
            5'b01100: begin strb.aluOp = OP_MULL; strb.wrEn = 1'b1; end
            5'b0111?: begin strb.aluOp = OP_SLL; strb.wrEn = 1'b1; end
            5'b1000?: begin strb.aluOp = OP_SRL; strb.wrEn = 1'b1; end
            5'b1001?: begin strb.aluOp = OP_SRA; strb.wrEn = 1'b1; end
            5'b1010?: begin strb.aluOp = OP_SLL; strb.wrEn = 1'b1; strb.shiftReg = 1'b1; end
            5'b1011?: begin strb.aluOp = OP_SRL; strb.wrEn = 1'b1; strb.shiftReg = 1'b1; end
            5'b1100?: begin strb.aluOp = OP_SRA; strb.wrEn = 1'b1; strb.shiftReg = 1'b1; end
            5'b11010: begin strb.aluOp = OP_PASS; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            default:  strb.illegal = 1'b1;
          endcase
        end
        CLS_IMM: begin
          unique case (immOp)
            3'b000: begin strb.aluOp = OP_ADD; strb.useImm = 1'b1; strb.immSext = 1'b1;
                          strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            3'b001: begin strb.aluOp = OP_SUB; strb.useImm = 1'b1; strb.immSext = 1'b1;
                          strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            3'b010: begin strb.aluOp = OP_SUB; strb.useImm = 1'b1; strb.immSext = 1'b1;
                          strb.setNZ = 1'b1; strb.setArith = 1'b1; end
            3'b011: begin strb.aluOp = OP_AND; strb.useImm = 1'b1;
                          strb.wrEn = 1'b1; strb.setNZ = 1'b1; strb.clrO = 1'b1; end
            3'b100: begin strb.aluOp = OP_LUI; strb.wrEn = 1'b1; end
            3'b101: strb.condBr = 1'b1;
            default: strb.jump = 1'b1;
          endcase
        end
        default: ;  // memory classes: handled by another stage
      endcase
    end
  end

endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlS             strb,
  input  logic [DW-1:0]    opA,
  input  logic [DW-1:0]    opB,
  input  logic [IMM_W-1:0] imm,
  input  logic             shiftMode,
  input  logic [2:0]       brMask,
  output logic [DW-1:0]    result,
  output logic             branchTaken,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagO,
  output logic             flagC
);

  localparam int SHW = 4;

  logic [DW-1:0]   immExt;
  logic [DW-1:0]   opSel;
  logic [DW-1:0]   addIn2;
  logic            addCin;
  logic [DW:0]     addSum;
  logic            addOvf;
  logic [1:0]      shStep;
  logic [SHW-1:0]  shAmt;
  logic [2*DW-1:0] product;

  assign immExt = strb.immSext ? {{(DW-IMM_W){imm[IMM_W-1]}}, imm}
                               : {{(DW-IMM_W){1'b0}}, imm};
  assign opSel  = strb.useImm ? immExt : opB;

  // Shared adder for add, subtract, compare and add-with-carry
  assign addIn2 = (strb.aluOp == OP_SUB) ? ~opSel : opSel;
  assign addCin = (strb.aluOp == OP_SUB) ? 1'b1 :
                  (strb.aluOp == OP_ADC) ? flagC : 1'b0;
  assign addSum = {1'b0, opA} + {1'b0, addIn2} + {{DW{1'b0}}, addCin};
  assign addOvf = (opA[DW-1] == addIn2[DW-1]) && (addSum[DW-1] != opA[DW-1]);

  // Step count scaled by one or by four
  assign shStep = strb.shiftReg ? opB[1:0] : imm[1:0];
  assign shAmt  = shiftMode ? {shStep, 2'b00} : {2'b00, shStep};

  assign product = opA * opB;

  always_comb begin
    unique case (strb.aluOp)
      OP_ADD, OP_SUB, OP_ADC: result = addSum[DW-1:0];
      OP_AND:  result = opA & opSel;
      OP_OR:   result = opA | opSel;
      OP_XOR:  result = opA ^ opSel;
      OP_NOT:  result = ~opA;
      OP_MULH: result = product[2*DW-1:DW];
      OP_MULL: result = product[DW-1:0];
      OP_SLL:  result = opA << shAmt;
      OP_SRL:  result = opA >> shAmt;
      OP_SRA:  result = $unsigned($signed(opA) >>> shAmt);
      OP_LUI:  result = {imm, {(DW-IMM_W){1'b0}}};
      default: result = opA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagO <= 1'b0;
      flagC <= 1'b0;
    end else begin
      if (strb.setNZ) begin
        flagN <= result[DW-1];
        flagZ <= (result == '0);
      end
      if (strb.setArith) begin
        flagO <= addOvf;
        flagC <= addSum[DW];
      end else if (strb.clrO) begin
        flagO <= 1'b0;
      end
    end
  end

  assign branchTaken = strb.jump |
                       (strb.condBr & |(brMask & {flagN, flagZ, flagO}));

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flagN && flagZ));  // R3
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.setArith |=> $stable(flagC));  // R4
  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.illegal |=> $stable({flagN, flagZ, flagO, flagC}));  // R12

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] result,
  output logic          wrEn,
  output logic          branchTaken,
  output logic          illegal,
  output logic          flagN,
  output logic          flagZ,
  output logic          flagO,
  output logic          flagC
);

  ctrlS strb;

  exec_ctrl u_ctrl (
    .inValid (inValid),
    .cls     (instr[15:14]),
    .immOp   (instr[10:8]),
    .func    (instr[7:3]),
    .strb    (strb)
  );

  exec_dp #(.DW(DW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .opA         (opA),
    .opB         (opB),
    .imm         (instr[7:0]),
    .shiftMode   (instr[3]),
    .brMask      (instr[13:11]),
    .result      (result),
    .branchTaken (branchTaken),
    .flagN       (flagN),
    .flagZ       (flagZ),
    .flagO       (flagO),
    .flagC       (flagC)
  );

  assign wrEn    = strb.wrEn;
  assign illegal = strb.illegal;

  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    branchTaken |-> !wrEn);  // R11
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wrEn && !branchTaken));  // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> (!wrEn && !branchTaken && !illegal));  // R1

endmodule

// File: tb/exec_unit_tb.sv
module exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] result;
  logic        wrEn, branchTaken, illegal;
  logic        flagN, flagZ, flagO, flagC;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference flag state and expectations
  logic mN = 0, mZ = 0, mO = 0, mC = 0;
  logic [15:0] eRes;
  logic eWr, eBr, eIll;
  logic nN, nZ, nO, nC;

  always #10 clk = ~clk;  // 50 MHz

  exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .opA(opA), .opB(opB), .result(result), .wrEn(wrEn),
    .branchTaken(branchTaken), .illegal(illegal),
    .flagN(flagN), .flagZ(flagZ), .flagO(flagO), .flagC(flagC)
  );

  function automatic logic [15:0] rw(input logic [4:0] fn, input logic [2:0] lo);
    return {2'b00, 6'b000000, fn, lo};
  endfunction

  function automatic logic [15:0] iw(input logic [2:0] op, input logic [7:0] im);
    return {2'b01, 3'b000, op, im};
  endfunction

  task automatic arith(input logic [15:0] a, input logic [15:0] y, input logic cin);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, y} + {16'd0, cin};
    eRes = s[15:0];
    nC = s[16];
    nO = (a[15] == y[15]) && (s[15] != a[15]);
    nN = s[15];
    nZ = (s[15:0] == 16'd0);
  endtask

  task automatic logicRes(input logic [15:0] v);
    eRes = v; nN = v[15]; nZ = (v == 16'd0); nO = 1'b0;
  endtask

  task automatic model(input logic v, input logic [15:0] i, input logic [15:0] a,
                       input logic [15:0] b);
    logic [4:0]  fn;
    logic [15:0] sx;
    logic [31:0] p;
    int amt;
    fn = i[7:3];
    sx = {{8{i[7]}}, i[7:0]};
    p  = a * b;
    eRes = 'x; eWr = 0; eBr = 0; eIll = 0;
    nN = mN; nZ = mZ; nO = mO; nC = mC;
    if (v && i[15:14] == 2'b00) begin
      amt = (fn[4:1] >= 4'b1010) ? int'(b[1:0]) : int'(i[1:0]);
      if (fn[0]) amt = amt * 4;
      case (fn)
        5'b00000, 5'b00100: begin arith(a, b, 1'b0); eWr = 1; end
        5'b00001, 5'b00101: begin arith(a, ~b, 1'b1); eWr = 1; end
        5'b00010, 5'b00110: begin logicRes(a | b); eWr = 1; end
        5'b00011, 5'b00111: begin logicRes(a & b); eWr = 1; end
        5'b01000: begin arith(a, b, mC); eWr = 1; end
        5'b01001: begin logicRes(a ^ b); eWr = 1; end
        5'b01010: begin logicRes(~a); eWr = 1; end
        5'b01011: begin eRes = p[31:16]; eWr = 1; end
        5'b01100: begin eRes = p[15:0]; eWr = 1; end
        5'b01110, 5'b01111, 5'b10100, 5'b10101: begin eRes = a << amt; eWr = 1; end
        5'b10000, 5'b10001, 5'b10110, 5'b10111: begin eRes = a >> amt; eWr = 1; end
        5'b10010, 5'b10011, 5'b11000, 5'b11001: begin
          eRes = $unsigned($signed(a) >>> amt); eWr = 1; end
        5'b11010: begin logicRes(a); eRes = 'x; end
        default: eIll = 1;
      endcase
    end else if (v && i[15:14] == 2'b01) begin
      case (i[10:8])
        3'b000: begin arith(a, sx, 1'b0); eWr = 1; end
        3'b001: begin arith(a, ~sx, 1'b1); eWr = 1; end
        3'b010: begin arith(a, ~sx, 1'b1); eRes = 'x; end
        3'b011: begin logicRes(a & {8'h00, i[7:0]}); eWr = 1; end
        3'b100: begin eRes = {i[7:0], 8'h00}; eWr = 1; end
        3'b101: eBr = (i[13] & mN) | (i[12] & mZ) | (i[11] & mO);
        default: eBr = 1;
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one word, check combinational outputs, then the stored flags
  task automatic step(input string req, input logic v, input logic [15:0] i,
                      input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    inValid = v; instr = i; opA = a; opB = b;
    model(v, i, a, b);
    #2;
    check(req, {29'd0, wrEn, branchTaken, illegal}, {29'd0, eWr, eBr, eIll}, "ctl");
    if (eWr) check(req, {16'd0, result}, {16'd0, eRes}, "result");
    @(posedge clk);
    #1;
    mN = nN; mZ = nZ; mO = nO; mC = nC;
    check(req, {28'd0, flagN, flagZ, flagO, flagC}, {28'd0, mN, mZ, mO, mC}, "flags");
    inValid = 0;
  endtask

  task automatic testReset();
    #2;
    check("R1", {28'd0, flagN, flagZ, flagO, flagC}, 32'd0, "reset flags");
    check("R1", {29'd0, wrEn, branchTaken, illegal}, 32'd0, "reset ctl");
    step("R1", 1'b0, rw(5'b00000, 3'd0), 16'h8000, 16'h8000);
    step("R1", 1'b0, iw(3'b111, 8'h00), 16'h1, 16'h1);
  endtask

  task automatic testArith();
    step("R3", 1, rw(5'b00000, 0), 16'h7FFF, 16'h0001);  // signed overflow
    step("R3", 1, rw(5'b00100, 0), 16'hFFFF, 16'h0001);  // carry and zero
    step("R3", 1, rw(5'b00001, 0), 16'h0003, 16'h0005);  // borrow
    step("R3", 1, rw(5'b00101, 0), 16'h8000, 16'h0001);  // overflow on sub
    for (int k = 0; k < 20; k++)
      step("R3", 1, rw(k[0] ? 5'b00001 : 5'b00100, 0), 16'($urandom), 16'($urandom));
  endtask

  task automatic testLogic();
    step("R3", 1, rw(5'b00000, 0), 16'hFFFF, 16'h0002);  // set C and leave it
    step("R4", 1, rw(5'b00111, 0), 16'hF0F0, 16'h0F0F);  // zero result
    step("R4", 1, rw(5'b01010, 0), 16'h0000, 16'h0000);  // not -> negative
    for (int k = 0; k < 16; k++) begin
      logic [4:0] fns [4] = '{5'b00010, 5'b00011, 5'b01001, 5'b01010};
      step("R4", 1, rw(fns[k % 4], 0), 16'($urandom), 16'($urandom));
    end
  endtask

  task automatic testAddc();
    step("R5", 1, rw(5'b00000, 0), 16'hFFFF, 16'h0001);  // carry out
    step("R5", 1, rw(5'b01000, 0), 16'h0000, 16'h0000);  // consumes it
    step("R5", 1, rw(5'b01000, 0), 16'h0000, 16'h0000);  // carry now gone
    for (int k = 0; k < 10; k++) begin
      step("R5", 1, rw(5'b00000, 0), 16'($urandom), 16'($urandom));
      step("R5", 1, rw(5'b01000, 0), 16'($urandom), 16'($urandom));
    end
  endtask

  task automatic testMul();
    step("R6", 1, rw(5'b01011, 0), 16'hFFFF, 16'hFFFF);
    step("R6", 1, rw(5'b01100, 0), 16'hFFFF, 16'hFFFF);
    for (int k = 0; k < 10; k++)
      step("R6", 1, rw(k[0] ? 5'b01011 : 5'b01100, 0), 16'($urandom), 16'($urandom));
  endtask

  task automatic testShiftImm();
    for (int f = 0; f < 3; f++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 4; s++)
          step("R7", 1, rw({4'(4'b0111 + f), 1'(m)}, {1'b0, 2'(s)}), 16'hB3C5, 16'($urandom));
    step("R7", 1, rw(5'b10011, 3'b011), 16'h8000, 16'h0);  // sra by 12
  endtask

  task automatic testShiftReg();
    for (int f = 0; f < 3; f++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 4; s++)
          step("R8", 1, rw({4'(4'b1010 + f), 1'(m)}, 3'b000), 16'($urandom),
               {14'($urandom), 2'(s)});
  endtask

  task automatic testImm();
    step("R9", 1, iw(3'b000, 8'hFF), 16'h0001, 16'h0);  // +(-1) -> zero, carry
    step("R9", 1, iw(3'b001, 8'h80), 16'h7FFF, 16'h0);  // -(-128) overflow
    step("R9", 1, iw(3'b011, 8'hFF), 16'h8A5A, 16'h0);  // zero-extended mask
    step("R9", 1, iw(3'b100, 8'hA5), 16'h1234, 16'h0);
    for (int k = 0; k < 12; k++)
      step("R9", 1, iw(3'(k % 5 == 2 ? 0 : k % 5), 8'($urandom)), 16'($urandom), 16'h0);
  endtask

  task automatic testCmpTest();
    step("R10", 1, iw(3'b010, 8'h05), 16'h0005, 16'h0);
    step("R10", 1, iw(3'b010, 8'h06), 16'h0005, 16'h0);
    step("R10", 1, rw(5'b11010, 0), 16'h8001, 16'h0);
    step("R10", 1, rw(5'b11010, 0), 16'h0000, 16'h0);
  endtask

  task automatic testBranch();
    step("R11", 1, iw(3'b010, 8'h05), 16'h0005, 16'h0);   // Z=1
    step("R11", 1, {2'b01, 3'b010, 3'b101, 8'h00}, 16'h0, 16'h0);  // z mask taken
    step("R11", 1, {2'b01, 3'b101, 3'b101, 8'h00}, 16'h0, 16'h0);  // n,o not taken
    step("R11", 1, rw(5'b00000, 0), 16'h7FFF, 16'h0001);   // N=1 O=1
    step("R11", 1, {2'b01, 3'b001, 3'b101, 8'h00}, 16'h0, 16'h0);  // o taken
    step("R11", 1, {2'b01, 3'b000, 3'b101, 8'h00}, 16'h0, 16'h0);  // no mask
    step("R11", 1, iw(3'b110, 8'h00), 16'h0, 16'h0);
    step("R11", 1, iw(3'b111, 8'h3C), 16'h0, 16'h0);
    for (int k = 0; k < 8; k++)
      step("R11", 1, {2'b01, 3'(k), 3'b101, 8'h00}, 16'h0, 16'h0);
  endtask

  task automatic testIllegal();
    step("R3", 1, rw(5'b00000, 0), 16'hFFFF, 16'hFFFF);  // N=1 C=1 first
    step("R12", 1, rw(5'b11011, 0), 16'h0000, 16'h0000);
    step("R12", 1, rw(5'b01101, 0), 16'h0000, 16'h0000);
    for (int k = 28; k < 32; k++)
      step("R12", 1, rw(5'(k), 0), 16'h0, 16'h0);
  endtask

  task automatic testMemClass();
    step("R5", 1, rw(5'b00000, 0), 16'h8000, 16'h8000);  // O=1 C=1 Z=1
    step("R2", 1, {2'b10, 14'h0000}, 16'h0, 16'h0);
    step("R2", 1, {2'b11, 14'h3FFF}, 16'hFFFF, 16'hFFFF);
    step("R2", 1, {2'b10, 6'd0, 5'b11011, 3'd0}, 16'h1, 16'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testArith();
    testLogic();
    testAddc();
    testMul();
    testShiftImm();
    testShiftReg();
    testImm();
    testCmpTest();
    testBranch();
    testIllegal();
    testMemClass();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule